// File: doc/BRIEF.md
# Vector Compare and Condition-Code Unit

This unit is the comparison slice of a shader core's arithmetic path. It takes two already swizzled four-lane operands in a 24-bit floating-point format and an operation code. From these it produces either a four-lane result vector or an update to a two-bit condition-code register. Register fetch, swizzling, other arithmetic and branching on the condition codes are handled by neighbouring logic.

The number format has a sign bit, a 7-bit exponent biased by 63 and a 16-bit mantissa. When the exponent is all ones and the mantissa is nonzero, the value is NaN. Both zeros compare as equal. Every ordered relation with a NaN operand is false, and not-equal is true.

Five operations exist:
- CMP sets each condition bit from one lane under its own compare mode.
- SGE and SLT write a per-lane 1.0 or 0.0.
- MAX and MIN pick a source per lane. They choose the first source only when the strict relation holds, so NaN passes through only from the second source.

Results are registered one cycle after an issued operation.

Top module: `vcmp_unit`

## Requirements
- R1: While reset is asserted, and after it is released with no issue, `res` reads all zero and `cc` reads 2'b00.
- R2: An issued CMP (op 0) sets `cc[0]` from lane x (bits 23:0) under `mode_x` and `cc[1]` from lane y (bits 47:24) under `mode_y`, visible one clock later. The modes are 0 equal, 1 not equal, 2 less, 3 less-or-equal, 4 greater and 5 greater-or-equal. CMP leaves `res` unchanged.
- R3: A compare mode of 6 or 7 leaves its condition bit unchanged, while the other bit still updates.
- R4: An issued SGE (op 1) writes 24'h3F0000 (1.0) to each lane where src_a >= src_b and zero elsewhere. It leaves `cc` unchanged.
- R5: An issued SLT (op 2) writes 24'h3F0000 to each lane where src_a < src_b and zero elsewhere.
- R6: An issued MAX (op 3) writes src_a to a lane only when src_a > src_b, and otherwise writes src_b. Thus max(0, NaN) gives NaN and max(NaN, 0) gives 0.
- R7: An issued MIN (op 4) writes src_a to a lane only when src_a < src_b, and otherwise writes src_b, with the same NaN asymmetry as MAX.
- R8: A value with exponent 7'h7F and a nonzero mantissa is NaN. Every ordered relation involving NaN is false, not-equal with NaN is true, and +0 equals -0. Values order correctly across signs and exponents.
- R9: With `issue` low, or with op 5 to 7, neither `res` nor `cc` changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue | input | 1 | Operation valid this cycle |
| op | input | 3 | 0 CMP, 1 SGE, 2 SLT, 3 MAX, 4 MIN |
| mode_x | input | 3 | Compare mode for condition bit 0 |
| mode_y | input | 3 | Compare mode for condition bit 1 |
| src_a | input | 96 | First operand, lane x in the low 24 bits |
| src_b | input | 96 | Second operand, same lane layout |
| res | output | 96 | Registered per-lane result |
| cc | output | 2 | Condition-code register |

## Verification
Within a single CMP, one condition bit can update while the other holds under an unrecognised mode. The bench provokes this by issuing CMP with a valid mode on one lane and mode 6 or 7 on the other. The bench first drives the held bit to a value that a real compare would overturn, then checks that the bit kept that earlier value while its partner took the new one. A second overlap is a CMP following a result-writing operation: the bench requires `res` to remain at the earlier result while `cc` changes.

// File: rtl/vcmp_unit.sv
module vcmp_unit #(
  parameter int EXP_W = 7,
  parameter int MAN_W = 16,
  parameter int LANES = 4,
  localparam int FW = 1 + EXP_W + MAN_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue,
  input  logic [2:0]         op,
  input  logic [2:0]         mode_x,
  input  logic [2:0]         mode_y,
  input  logic [LANES*FW-1:0] src_a,
  input  logic [LANES*FW-1:0] src_b,
  output logic [LANES*FW-1:0] res,
  output logic [1:0]         cc
);

  localparam logic [2:0] OP_CMP = 3'd0;
  localparam logic [2:0] OP_SGE = 3'd1;
  localparam logic [2:0] OP_SLT = 3'd2;
  localparam logic [2:0] OP_MAX = 3'd3;
  localparam logic [2:0] OP_MIN = 3'd4;
  localparam logic [FW-1:0] ONE_VAL = {2'b00, {(EXP_W-1){1'b1}}, {MAN_W{1'b0}}};

  function automatic logic is_nan(input logic [FW-1:0] v);
    return (&v[FW-2:MAN_W]) && (|v[MAN_W-1:0]);
  endfunction

  // monotonic unsigned key; both zeros collapse onto one key
  function automatic logic [FW-1:0] order_key(input logic [FW-1:0] v);
    logic [FW-1:0] z;
    z = (v[FW-2:0] == '0) ? '0 : v;
    return z[FW-1] ? ~z : {1'b1, z[FW-2:0]};
  endfunction

  function automatic logic mode_hit(input logic [2:0] m, input logic un, input logic lt,
                                    input logic eq, input logic prev);
    case (m)
      3'd0:    return eq;
      3'd1:    return !eq;
      3'd2:    return lt;
      3'd3:    return lt || eq;
      3'd4:    return !un && !lt && !eq;
      3'd5:    return !un && !lt;
      default: return prev;
    endcase
  endfunction

  logic [LANES-1:0]    l_un, l_lt, l_eq;
  logic [LANES*FW-1:0] res_nxt;
  logic [1:0]          cc_nxt;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [FW-1:0] a, b, ka, kb;
    logic          gt;
    assign a  = src_a[i*FW +: FW];
    assign b  = src_b[i*FW +: FW];
    assign ka = order_key(a);
    assign kb = order_key(b);
    assign l_un[i] = is_nan(a) || is_nan(b);
    assign l_lt[i] = !l_un[i] && (ka < kb);
    assign l_eq[i] = !l_un[i] && (ka == kb);
    assign gt      = !l_un[i] && (ka > kb);

    always_comb begin
      case (op)
        OP_SGE:  res_nxt[i*FW +: FW] = (!l_un[i] && !l_lt[i]) ? ONE_VAL : '0;
        OP_SLT:  res_nxt[i*FW +: FW] = l_lt[i] ? ONE_VAL : '0;
        OP_MAX:  res_nxt[i*FW +: FW] = gt ? a : b;
        OP_MIN:  res_nxt[i*FW +: FW] = l_lt[i] ? a : b;
        default: res_nxt[i*FW +: FW] = res[i*FW +: FW];
      endcase
    end

    assert_sge_domain_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && op == OP_SGE) |=> (res[i*FW +: FW] == ONE_VAL || res[i*FW +: FW] == '0));

    assert_max_pick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && op == OP_MAX) |=> (res[i*FW +: FW] == $past(src_a[i*FW +: FW]) ||
                                   res[i*FW +: FW] == $past(src_b[i*FW +: FW])));
  end

  assign cc_nxt[0] = mode_hit(mode_x, l_un[0], l_lt[0], l_eq[0], cc[0]);
  assign cc_nxt[1] = mode_hit(mode_y, l_un[1], l_lt[1], l_eq[1], cc[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res <= '0;
      cc  <= '0;
    end else if (issue) begin
      case (op)
        OP_CMP:                         cc  <= cc_nxt;
        OP_SGE, OP_SLT, OP_MAX, OP_MIN: res <= res_nxt;
        default: ;
      endcase
    end
  end

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue || op > OP_MIN) |=> ($stable(cc) && $stable(res)));

  assert_cmp_keeps_res_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op == OP_CMP) |=> $stable(res));

  assert_bad_mode_x_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op == OP_CMP && mode_x > 3'd5) |=> (cc[0] == $past(cc[0])));

  assert_bad_mode_y_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op == OP_CMP && mode_y > 3'd5) |=> (cc[1] == $past(cc[1])));

  assert_result_keeps_cc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op != OP_CMP) |=> $stable(cc));

endmodule

// File: tb/vcmp_unit_tb_top.sv
module vcmp_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  localparam logic [23:0] F_0   = 24'h000000;
  localparam logic [23:0] F_N0  = 24'h800000;
  localparam logic [23:0] F_1   = 24'h3F0000;
  localparam logic [23:0] F_2   = 24'h400000;
  localparam logic [23:0] F_H   = 24'h3E0000;
  localparam logic [23:0] F_M1  = 24'hBF0000;
  localparam logic [23:0] F_M2  = 24'hC00000;
  localparam logic [23:0] F_INF = 24'h7F0000;
  localparam logic [23:0] F_NAN = 24'h7F0001;

  typedef struct packed {
    logic [2:0]  op;
    logic [2:0]  mx;
    logic [2:0]  my;
    logic [95:0] a;
    logic [95:0] b;
    logic [95:0] r;
    logic [1:0]  c;
  } vec_t;

  // vectors written {w, z, y, x}
  localparam vec_t TBL [12] = '{
    '{3'd1, 3'd0, 3'd0, {F_N0, F_M1, F_1, F_1},   {F_0, F_M2, F_1, F_2},   {F_1, F_1, F_1, F_0},     2'b00}, // R4
    '{3'd2, 3'd0, 3'd0, {F_NAN, F_M2, F_H, F_M1}, {F_1, F_M1, F_1, F_0},   {F_0, F_1, F_1, F_1},     2'b00}, // R5 R8
    '{3'd3, 3'd0, 3'd0, {F_NAN, F_0, F_2, F_M1},  {F_0, F_NAN, F_1, F_H},  {F_0, F_NAN, F_2, F_H},   2'b00}, // R6
    '{3'd4, 3'd0, 3'd0, {F_NAN, F_0, F_M2, F_2},  {F_0, F_NAN, F_M1, F_1}, {F_0, F_NAN, F_M2, F_1},  2'b00}, // R7
    '{3'd0, 3'd0, 3'd2, {F_0, F_0, F_1, F_0},     {F_0, F_0, F_2, F_N0},   {F_0, F_NAN, F_M2, F_1},  2'b11}, // R2 R8
    '{3'd0, 3'd1, 3'd4, {F_0, F_0, F_1, F_NAN},   {F_0, F_0, F_NAN, F_1},  {F_0, F_NAN, F_M2, F_1},  2'b01}, // R2 R8
    '{3'd0, 3'd3, 3'd5, {F_0, F_0, F_M2, F_M1},   {F_0, F_0, F_M1, F_M1},  {F_0, F_NAN, F_M2, F_1},  2'b01}, // R2
    '{3'd0, 3'd6, 3'd1, {F_0, F_0, F_NAN, F_2},   {F_0, F_0, F_NAN, F_0},  {F_0, F_NAN, F_M2, F_1},  2'b11}, // R3
    '{3'd0, 3'd4, 3'd7, {F_0, F_0, F_0, F_1},     {F_0, F_0, F_1, F_2},    {F_0, F_NAN, F_M2, F_1},  2'b10}, // R3
    '{3'd0, 3'd2, 3'd3, {F_0, F_0, F_0, F_NAN},   {F_0, F_0, F_NAN, F_1},  {F_0, F_NAN, F_M2, F_1},  2'b00}, // R8
    '{3'd3, 3'd0, 3'd0, {F_INF, F_M1, F_0, F_N0}, {F_2, F_M2, F_N0, F_0},  {F_INF, F_M1, F_N0, F_0}, 2'b00}, // R6 R8
    '{3'd1, 3'd0, 3'd0, {F_NAN, F_INF, F_0, F_M2},{F_NAN, F_INF, F_N0, F_M2},{F_0, F_1, F_1, F_1},   2'b00}  // R4 R8
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [2:0]  op = '0, mode_x = '0, mode_y = '0;
  logic [95:0] src_a = '0, src_b = '0;
  logic [95:0] res;
  logic [1:0]  cc;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vcmp_unit dut_i (
    .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .mode_x(mode_x), .mode_y(mode_y),
    .src_a(src_a), .src_b(src_b), .res(res), .cc(cc)
  );

  function automatic string tag_of(input logic [2:0] o);
    case (o)
      3'd0: return "R2/R3/R8";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [95:0] er, input logic [1:0] ec);
    n_chk++;
    if (res !== er || cc !== ec) begin
      n_bad++;
      $display("FAIL %s: res=%h cc=%b expected res=%h cc=%b", tag, res, cc, er, ec);
    end
  endtask

  task automatic drive(input logic go, input logic [2:0] o, input logic [2:0] mx,
                       input logic [2:0] my, input logic [95:0] a, input logic [95:0] b);
    @(negedge clk);
    issue = go; op = o; mode_x = mx; mode_y = my; src_a = a; src_b = b;
    @(negedge clk);
    issue = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 4000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [95:0] last_r;
    logic [1:0]  last_c;
    repeat (3) @(negedge clk);
    check("R1 in reset", '0, 2'b00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after release", '0, 2'b00);

    for (int k = 0; k < 12; k++) begin
      drive(1'b1, TBL[k].op, TBL[k].mx, TBL[k].my, TBL[k].a, TBL[k].b);
      check($sformatf("%s entry %0d", tag_of(TBL[k].op), k), TBL[k].r, TBL[k].c);
    end

    // R9: no issue, inputs that would change both outputs
    last_r = res; last_c = cc;
    drive(1'b0, 3'd0, 3'd1, 3'd1, {4{F_1}}, {4{F_2}});
    check("R9 issue low, CMP inputs", last_r, last_c);
    drive(1'b0, 3'd3, 3'd0, 3'd0, {4{F_2}}, {4{F_1}});
    check("R9 issue low, MAX inputs", last_r, last_c);
    // R9: unused opcodes
    for (int o = 5; o < 8; o++) begin
      drive(1'b1, 3'(o), 3'd1, 3'd1, {4{F_2}}, {4{F_M1}});
      check($sformatf("R9 unused op %0d", o), last_r, last_c);
    end

    // R3 overlap: x held at 1 by mode 7 while y updates to 0
    drive(1'b1, 3'd0, 3'd0, 3'd0, {F_0, F_0, F_1, F_1}, {F_0, F_0, F_1, F_1});
    check("R2 both equal", last_r, 2'b11);
    drive(1'b1, 3'd0, 3'd7, 3'd4, {F_0, F_0, F_1, F_1}, {F_0, F_0, F_2, F_2});
    check("R3 x held, y cleared", last_r, 2'b01);

    // R4 SGE leaves cc alone, then CMP leaves res alone (R2)
    drive(1'b1, 3'd1, 3'd0, 3'd0, {F_M1, F_2, F_NAN, F_0}, {F_M2, F_2, F_0, F_N0});
    check("R4 SGE keeps cc", {F_1, F_1, F_0, F_1}, 2'b01);
    drive(1'b1, 3'd0, 3'd2, 3'd2, {F_0, F_0, F_M2, F_M1}, {F_0, F_0, F_1, F_1});
    check("R2 CMP keeps res", {F_1, F_1, F_0, F_1}, 2'b11);

    // R5 with zero signs and infinity
    drive(1'b1, 3'd2, 3'd0, 3'd0, {F_M1, F_N0, F_1, F_INF}, {F_NAN, F_0, F_INF, F_2});
    check("R5 SLT zeros/inf", {F_0, F_0, F_1, F_0}, 2'b11);

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid-run", '0, 2'b00);
    rst_n = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule